// File: doc/BRIEF.md
# Frame-Loss Defect Clearance Monitor

This block holds the loss-of-frame (LOF) defect state for an STS-3 receive framer. Upstream logic asks for the defect to be declared. The block then clears it under its own rule. LOF may leave the declared state only while the severely-errored-frame (SEF) defect is inactive. It also needs a run of consecutive frames whose A1/A2 framing bytes arrived without error, and the run must reach a software-programmed length. A single errored frame, or SEF coming back, restarts the run.

Every change of the LOF state latches a change-of-LOF interrupt flag. Reading that flag clears it. When its enable is set, the flag pulls an active-low interrupt pin. A small register port lets software program the run length, read the live defect bit, read and clear the interrupt flag, and set the interrupt enable. The framer feeds the block one strobe per frame, together with that frame's framing-check result and the current SEF state.

Top module: `lof_clear_monitor`

## Requirements
- R1: Out of reset, LOF reads 1, the interrupt flag reads 0, the interrupt enable is 0, the threshold register reads 2 and `irq_n` is high.
- R2: While `sef_active` is high, clean frames neither clear LOF nor count toward the run.
- R3: With SEF inactive and LOF set, LOF drops in the cycle after the strobe of the clean frame that brings the consecutive count up to the threshold, and not before.
- R4: A strobed frame with `frame_ok` low, or `sef_active` high in any cycle, resets the consecutive-clean count to zero.
- R5: A threshold of 0 behaves as 1, so a single clean frame clears LOF.
- R6: Address 0 holds the threshold in bits 3:0. It can be read and written, and bits 7:4 read 0.
- R7: Address 1 returns the live LOF state in bit 2 and 0 in every other bit. Writes to address 1 have no effect.
- R8: `lof_declare` sets LOF in the next cycle. It takes priority over a clearing frame in the same cycle and restarts the run.
- R9: Each LOF transition, set or clear, raises the interrupt flag at address 2 bit 2 in the same cycle that LOF changes. A declare while LOF is already set raises nothing. All other bits of address 2 read 0.
- R10: A read of address 2 returns the flag and clears it at the next edge. If a new LOF change occurs in the same cycle as the read, the flag stays set.
- R11: `irq_n` is low exactly when the interrupt flag and the enable at address 3 bit 2 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| frame_ok | input | 1 | Framing bytes of the strobed frame were error-free |
| sef_active | input | 1 | Current SEF defect state |
| lof_declare | input | 1 | Request to declare LOF |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the interrupt flag at address 2) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| lof_status | output | 1 | Live LOF defect state |
| lof_chg_irq | output | 1 | Change-of-LOF interrupt flag |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
The bench builds the block with its default parameters: a 4-bit threshold field and a reset threshold of 2. The 4-bit width makes the largest run, 15 clean frames, reachable in a few dozen cycles, so the top threshold is tested alongside the zero-to-one substitution. The reset value of 2 lets the bench observe the power-up threshold before it overwrites it. The directed tests also cover a declare arriving together with a clearing frame and a flag read in the same cycle as a new LOF change.

// File: rtl/lofclr_pkg.sv
package lofclr_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int LOF_BIT = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_THRESH = 2'd0,
        A_STATUS = 2'd1,
        A_ISTAT  = 2'd2,
        A_IEN    = 2'd3
    } reg_addr_e;

    typedef enum logic {
        ST_IN_FRAME = 1'b0,
        ST_LOF      = 1'b1
    } lof_state_e;

    typedef struct packed {
        logic stb;
        logic ok;
        logic sef;
        logic declare;
    } frame_ev_t;

    function automatic logic [DATA_W-1:0] place_lof_bit(input logic v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[LOF_BIT] = v;
        return r;
    endfunction

endpackage

// File: rtl/lofclr_run_counter.sv
module lofclr_run_counter
    import lofclr_pkg::*;
#(
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  frame_ev_t        ev,
    input  logic             lof,
    input  logic [THR_W-1:0] thresh,
    output logic             clear_req
);
    localparam int CNT_W = THR_W + 1;

    logic [THR_W-1:0] cnt;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] eff;
    logic             clean;

    always_comb begin
        eff       = (thresh == '0) ? CNT_W'(1) : CNT_W'(thresh);
        nxt       = CNT_W'(cnt) + CNT_W'(1);
        clean     = ev.stb && ev.ok && !ev.sef && !ev.declare && lof;
        clear_req = clean && (nxt >= eff);
    end

    always_ff @(posedge clk) begin
        if (rst || !lof || ev.sef || ev.declare) begin
            cnt <= '0;
        end else if (ev.stb) begin
            if (!ev.ok || clear_req) cnt <= '0;
            else                     cnt <= nxt[THR_W-1:0];
        end
    end

endmodule

// File: rtl/lofclr_defect_fsm.sv
module lofclr_defect_fsm
    import lofclr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic declare,
    input  logic clear_req,
    output logic lof,
    output logic changed
);
    lof_state_e st, st_nxt;

    always_comb begin
        st_nxt = st;
        if (declare)        st_nxt = ST_LOF;
        else if (clear_req) st_nxt = ST_IN_FRAME;
        changed = (st_nxt != st);
        lof     = (st == ST_LOF);
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_LOF;
        else     st <= st_nxt;
    end

endmodule

// File: rtl/lofclr_irq_ctrl.sv
module lofclr_irq_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic rd_clr,
    input  logic enable,
    output logic flag,
    output logic irq_n
);
    always_ff @(posedge clk) begin
        if (rst)         flag <= 1'b0;
        else if (set_ev) flag <= 1'b1;
        else if (rd_clr) flag <= 1'b0;
    end

    assign irq_n = !(flag && enable);

endmodule

// File: rtl/lof_clear_monitor.sv
module lof_clear_monitor
    import lofclr_pkg::*;
#(
    parameter int               THR_W     = 4,
    parameter logic [THR_W-1:0] THR_RESET = 4'd2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_stb,
    input  logic              frame_ok,
    input  logic              sef_active,
    input  logic              lof_declare,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              lof_status,
    output logic              lof_chg_irq,
    output logic              irq_n
);
    localparam int PAD_W = DATA_W - THR_W;

    frame_ev_t        ev;
    logic [THR_W-1:0] thresh;
    logic             ien;
    logic             clear_req;
    logic             changed;
    logic             rd_clr;

    assign ev = '{stb: frame_stb, ok: frame_ok, sef: sef_active, declare: lof_declare};
    assign rd_clr = reg_rd && (reg_addr == A_ISTAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            thresh <= THR_RESET;
            ien    <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == A_THRESH) thresh <= reg_wdata[THR_W-1:0];
            if (reg_addr == A_IEN)    ien    <= reg_wdata[LOF_BIT];
        end
    end

    always_comb begin
        case (reg_addr)
            A_THRESH: reg_rdata = {{PAD_W{1'b0}}, thresh};
            A_STATUS: reg_rdata = place_lof_bit(lof_status);
            A_ISTAT:  reg_rdata = place_lof_bit(lof_chg_irq);
            default:  reg_rdata = place_lof_bit(ien);
        endcase
    end

    lofclr_run_counter #(.THR_W(THR_W)) u_run (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .lof       (lof_status),
        .thresh    (thresh),
        .clear_req (clear_req)
    );

    lofclr_defect_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .declare   (lof_declare),
        .clear_req (clear_req),
        .lof       (lof_status),
        .changed   (changed)
    );

    lofclr_irq_ctrl u_irq (
        .clk    (clk),
        .rst    (rst),
        .set_ev (changed),
        .rd_clr (rd_clr),
        .enable (ien),
        .flag   (lof_chg_irq),
        .irq_n  (irq_n)
    );

endmodule

// File: rtl/lofclr_checker.sv
module lofclr_checker (
    input logic       clk,
    input logic       rst,
    input logic       frame_stb,
    input logic       frame_ok,
    input logic       sef_active,
    input logic       lof_declare,
    input logic       reg_rd,
    input logic [1:0] reg_addr,
    input logic       lof_status,
    input logic       lof_chg_irq,
    input logic       irq_n
);
    // R2
    sef_holds_lof_chk: assert property (@(posedge clk) disable iff (rst)
        (sef_active && lof_status) |=> lof_status);

    // R3
    clear_needs_clean_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lof_status) |-> $past(frame_stb && frame_ok && !sef_active && !lof_declare));

    // R8
    declare_sets_lof_chk: assert property (@(posedge clk) disable iff (rst)
        lof_declare |=> lof_status);

    // R9
    change_raises_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (lof_status != $past(lof_status)) |-> lof_chg_irq);

    // R10
    read_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 2'd2 && !lof_declare && !frame_stb) |=> !lof_chg_irq);

    // R11
    pin_idle_without_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !lof_chg_irq |-> irq_n);

endmodule

bind lof_clear_monitor lofclr_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_stb   (frame_stb),
    .frame_ok    (frame_ok),
    .sef_active  (sef_active),
    .lof_declare (lof_declare),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .lof_status  (lof_status),
    .lof_chg_irq (lof_chg_irq),
    .irq_n       (irq_n)
);

// File: tb/sim_lof_clear_monitor.sv
module sim_lof_clear_monitor;

    logic       clk = 1'b0;
    logic       rst;
    logic       frame_stb, frame_ok, sef_active, lof_declare;
    logic       reg_wr, reg_rd;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       lof_status, lof_chg_irq, irq_n;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    lof_clear_monitor u0 (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .frame_ok(frame_ok),
        .sef_active(sef_active), .lof_declare(lof_declare), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .lof_status(lof_status), .lof_chg_irq(lof_chg_irq),
        .irq_n(irq_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        frame_stb = 0; frame_ok = 0; lof_declare = 0;
        reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); idle();
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); idle();
    endtask

    task automatic frames(input int n, input logic ok);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); frame_stb = 1; frame_ok = ok;
            @(negedge clk); idle();
        end
    endtask

    task automatic declare();
        @(negedge clk); lof_declare = 1;
        @(negedge clk); idle();
    endtask

    task automatic clear_flag();
        logic [7:0] d;
        rd(2'd2, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 lof", lof_status, 1);
        check("R1 flag", lof_chg_irq, 0);
        check("R1 irq_n", irq_n, 1);
        rd(2'd0, d); check("R1 threshold reset", d, 2);
        rd(2'd3, d); check("R1 enable reset", d, 0);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(2'd0, 8'hF7); rd(2'd0, d); check("R6 threshold bits 3:0", d, 8'h07);
        wr(2'd1, 8'h00); rd(2'd1, d); check("R7 status bit2 ignores write", d, 8'h04);
        wr(2'd3, 8'h04); rd(2'd3, d); check("R11 enable bit2", d, 8'h04);
    endtask

    task automatic t_sef_block();
        wr(2'd0, 8'd3);
        sef_active = 1;
        frames(5, 1);
        check("R2 lof held under SEF", lof_status, 1);
        sef_active = 0;
        frames(2, 1);
        check("R2 no count under SEF", lof_status, 1);
    endtask

    task automatic t_clear();
        logic [7:0] d;
        frames(1, 1);
        check("R3 lof cleared at threshold", lof_status, 0);
        check("R9 flag on clear", lof_chg_irq, 1);
        check("R11 irq_n low", irq_n, 0);
        rd(2'd1, d); check("R7 status after clear", d, 0);
        rd(2'd2, d); check("R10 read returns flag", d, 8'h04);
        check("R10 flag cleared", lof_chg_irq, 0);
        check("R11 irq_n high after read", irq_n, 1);
    endtask

    task automatic t_errored_restart();
        declare();
        check("R8 declare sets lof", lof_status, 1);
        check("R9 flag on set", lof_chg_irq, 1);
        clear_flag();
        declare();
        check("R9 no flag when already set", lof_chg_irq, 0);
        frames(2, 1); frames(1, 0); frames(2, 1);
        check("R4 errored frame restarts run", lof_status, 1);
        frames(1, 1);
        check("R4 clears after fresh run", lof_status, 0);
        clear_flag();
    endtask

    task automatic t_sef_restart();
        declare(); clear_flag();
        frames(2, 1);
        @(negedge clk); sef_active = 1;
        @(negedge clk); sef_active = 0;
        frames(2, 1);
        check("R4 SEF restarts run", lof_status, 1);
        frames(1, 1);
        check("R4 clears after SEF run", lof_status, 0);
        clear_flag();
    endtask

    task automatic t_zero_and_max();
        declare(); clear_flag();
        wr(2'd0, 8'd0);
        frames(1, 1);
        check("R5 threshold 0 acts as 1", lof_status, 0);
        clear_flag();
        declare(); clear_flag();
        wr(2'd0, 8'd15);
        frames(14, 1);
        check("R3 14 of 15 not cleared", lof_status, 1);
        frames(1, 1);
        check("R3 15 of 15 cleared", lof_status, 0);
        clear_flag();
    endtask

    task automatic t_priority();
        declare(); clear_flag();
        wr(2'd0, 8'd1);
        @(negedge clk); frame_stb = 1; frame_ok = 1; lof_declare = 1;
        @(negedge clk); idle();
        check("R8 declare beats clearing frame", lof_status, 1);
        check("R8 no flag, no transition", lof_chg_irq, 0);
        @(negedge clk); frame_stb = 1; frame_ok = 1; reg_rd = 1; reg_addr = 2'd2;
        @(negedge clk); idle();
        check("R10 set wins over read", lof_chg_irq, 1);
        check("R3 cleared by single frame", lof_status, 0);
        wr(2'd3, 8'h00);
        check("R11 disabled pin high", irq_n, 1);
        clear_flag();
    endtask

    initial begin
        idle(); sef_active = 0; rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_sef_block();
        t_clear();
        t_errored_restart();
        t_sef_restart();
        t_zero_and_max();
        t_priority();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule